// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block collects interrupt requests from peripheral level lines and from software, keeps a per-line enable, pending and active bit, and forwards each pending, enabled line to the processors that should see it. Software reaches every register over a plain 32-bit register bus with byte strobes. Each state bit can only be changed by writing a one to a separate set word or clear word for that state, so concurrent updates of different lines never need a read-modify-write sequence.

Lines 0 to 15 are raised by software through a fan-out register. Lines 16 to 31 are private to each processor and come from a per-processor group of level inputs. Lines 32 upward are shared peripheral lines, and each one carries a target byte that picks the processors receiving it. A priority byte is kept for every line for use by a later selection stage. A single global switch gates all forwarding. The outputs are the pending-and-enabled set of every processor and one summary request bit per processor.

Top module: `irq_dist`

## Requirements
- R1: Enable and active each have a set word (offsets 0x100 and 0x300) and a clear word (0x180 and 0x380). A one bit in written data sets or clears the matching line, a zero bit leaves it alone, and reading either word returns the current state.
- R2: Line n maps to bit n mod 32 of word n/32 inside each state region, so the word offset is (n/32)*4. Regions beyond the implemented line count read zero.
- R3: Priority bytes start at 0x400. Line n sits in byte lane n mod 4 of the word at 0x400 + (n/4)*4. A write changes only the bytes whose strobe is set.
- R4: Target bytes start at 0x800 with the same lane packing. For lines 32 upward, bit c selects processor c and only the low NUM_CPU bits are kept (others read zero). For lines 0 to 31 the byte is read-only and returns the one-hot mask of the processor issuing the read.
- R5: The type word at 0x004 returns NUM_IRQ/32 - 1 in bits 4:0 and zero elsewhere. Writes to it have no effect.
- R6: A write to 0xF00 with a line number in bits 3:0 and a processor list in bits 23:16 marks that line pending for every listed processor, and for no other.
- R7: Pending state of lines 0 to 31 is kept per processor. The pending set word at 0x200 and clear word at 0x280 act on, and read back, the bank of the processor issuing the access. Lines 32 upward have one shared pending bit.
- R8: A high level input shows as pending one clock after it is sampled high. A pending clear while it is high has no lasting effect. Once it drops, the line stays pending only if software has set it.
- R9: Output bit c*NUM_IRQ + n is high exactly when forwarding is on, line n is enabled, and line n is pending for processor c. For lines 32 upward this also requires target bit c. Output cpu_irq_o[c] is the OR of processor c's set.
- R10: Bit 0 of the control word at 0x000 turns forwarding on. While it is zero no output bit is high.
- R11: Read data appears on the clock after the read request and is zero in every other cycle. Unmapped addresses, the fan-out register and any address with a bit set above bit 11 read zero.
- R12: After reset every enable, pending, active, priority, target and control bit is zero, and no output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes for writes |
| bus_cpu | input | CPU_W | Number of the processor making the access |
| bus_rdata | output | 32 | Read data, one clock after the request |
| spi_in | input | NUM_IRQ-32 | Level inputs of shared lines 32 upward |
| ppi_in | input | NUM_CPU*16 | Level inputs of private lines 16 to 31, 16 per processor |
| cpu_hit_o | output | NUM_CPU*NUM_IRQ | Pending-and-enabled set of each processor |
| cpu_irq_o | output | NUM_CPU | Any line forwarded to that processor |

## Verification
The bench builds the block with 64 lines and four processors. With that setting, word 0 of each state region holds the banked lines and word 1 holds the shared lines, so both kinds of line and the boundary between them are exercised. The target bytes keep four of eight bits, which brings the discarding of the upper target bits within reach. A type value of 1 and a processor field with no unused codes allow every access pattern to be compared against a bench model.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

   // state regions sit on 128-byte slots; the slot number is address bits 11:7
   typedef enum logic [4:0] {
      SV_EN_SET = 5'd2,
      SV_EN_CLR = 5'd3,
      SV_PD_SET = 5'd4,
      SV_PD_CLR = 5'd5,
      SV_AC_SET = 5'd6,
      SV_AC_CLR = 5'd7
   } st_view_e;

   // byte arrays sit on 1 KiB slots; the slot number is address bits 11:10
   localparam logic [1:0]  GRP_PRIO = 2'd1;
   localparam logic [1:0]  GRP_TGT  = 2'd2;

   localparam logic [11:0] ADR_CTRL = 12'h000;
   localparam logic [11:0] ADR_TYPE = 12'h004;
   localparam logic [11:0] ADR_SGI  = 12'hF00;
   localparam logic [11:0] ADR_TGT0 = 12'h800;

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      lane_mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

endpackage

// File: rtl/irq_dist_setclr.sv
module irq_dist_setclr #(
   parameter int NUM_IRQ = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] set_vec,
   input  logic [NUM_IRQ-1:0] clr_vec,
   output logic [NUM_IRQ-1:0] state_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o <= '0;
      else        state_o <= (state_o & ~clr_vec) | set_vec;
   end

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((state_o & $past(set_vec)) == $past(set_vec))); // R1
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec == '0) |=> ((state_o & $past(clr_vec)) == '0)); // R1
   AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec == '0 && clr_vec == '0) |=> $stable(state_o)); // R1

endmodule

// File: rtl/irq_dist_bytes.sv
module irq_dist_bytes #(
   parameter int NUM_IRQ   = 64,
   parameter int BYTE_W    = 8,
   parameter int FIXED_LOW = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [7:0]                word,
   input  logic [31:0]               wdata,
   input  logic [3:0]                be,
   output logic [NUM_IRQ*BYTE_W-1:0] bytes_o
);

   initial begin
      if (BYTE_W < 1 || BYTE_W > 8) $fatal(1, "irq_dist_bytes: BYTE_W must be 1..8");
      if (FIXED_LOW < 0 || FIXED_LOW > NUM_IRQ) $fatal(1, "irq_dist_bytes: bad FIXED_LOW");
   end

   for (genvar n = 0; n < NUM_IRQ; n++) begin : g_byte
      if (n < FIXED_LOW) begin : g_fixed
         assign bytes_o[n*BYTE_W +: BYTE_W] = '0;
      end else begin : g_store
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else if (we && word == 8'(n / 4) && be[n % 4])
               q <= wdata[(n % 4)*8 +: BYTE_W];
         end
         assign bytes_o[n*BYTE_W +: BYTE_W] = q;
      end
   end

   AST_BYTES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(bytes_o)); // R3

endmodule

// File: rtl/irq_dist_pend.sv
module irq_dist_pend #(
   parameter int NUM_IRQ = 64,
   parameter int NUM_CPU = 4,
   parameter int CPU_W   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_IRQ-33:0]     spi_in,
   input  logic [NUM_CPU*16-1:0]   ppi_in,
   input  logic [NUM_IRQ-1:0]      sw_set,
   input  logic [NUM_IRQ-1:0]      sw_clr,
   input  logic [CPU_W-1:0]        acc_cpu,
   input  logic                    sgi_we,
   input  logic [3:0]              sgi_id,
   input  logic [NUM_CPU-1:0]      sgi_list,
   output logic [NUM_CPU*32-1:0]   bank_o,
   output logic [NUM_IRQ-33:0]     pend_spi_o
);

   localparam int NSPI = NUM_IRQ - 32;

   logic [NUM_CPU*32-1:0] latch_b;
   logic [NUM_CPU*16-1:0] ppi_q;
   logic [NSPI-1:0]       latch_s;
   logic [NSPI-1:0]       spi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_b <= '0;
         latch_s <= '0;
         ppi_q   <= '0;
         spi_q   <= '0;
      end else begin
         ppi_q   <= ppi_in;
         spi_q   <= spi_in;
         latch_s <= (latch_s & ~sw_clr[NUM_IRQ-1:32]) | sw_set[NUM_IRQ-1:32];
         for (int c = 0; c < NUM_CPU; c++) begin
            for (int b = 0; b < 32; b++) begin
               if (sw_clr[b] && acc_cpu == CPU_W'(c))
                  latch_b[c*32+b] <= 1'b0;
               if ((sw_set[b] && acc_cpu == CPU_W'(c)) ||
                   (b < 16 && sgi_we && sgi_list[c] && sgi_id == 4'(b)))
                  latch_b[c*32+b] <= 1'b1;
            end
         end
      end
   end

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      for (genvar b = 0; b < 32; b++) begin : g_bit
         if (b < 16) begin : g_soft
            assign bank_o[c*32+b] = latch_b[c*32+b];
         end else begin : g_line
            assign bank_o[c*32+b] = latch_b[c*32+b] | ppi_q[c*16+b-16];
         end
      end
      AST_SGI_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
         (sgi_we && sgi_list[c]) |=> bank_o[c*32 + 32'($past(sgi_id))]); // R6
   end

   assign pend_spi_o = latch_s | spi_q;

   AST_LEVEL_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_spi_o & $past(spi_in)) == $past(spi_in))); // R8
   AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_set[NUM_IRQ-1:32] == '0) |=>
         ((pend_spi_o & $past(sw_clr[NUM_IRQ-1:32]) & ~$past(spi_in)) == '0)); // R8

endmodule

// File: rtl/irq_dist.sv
module irq_dist
   import irq_dist_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int NUM_CPU = 4,
   parameter int ADDR_W  = 12,
   parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_req,
   input  logic                       bus_we,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [31:0]                bus_wdata,
   input  logic [3:0]                 bus_be,
   input  logic [CPU_W-1:0]           bus_cpu,
   output logic [31:0]                bus_rdata,
   input  logic [NUM_IRQ-33:0]        spi_in,
   input  logic [NUM_CPU*16-1:0]      ppi_in,
   output logic [NUM_CPU*NUM_IRQ-1:0] cpu_hit_o,
   output logic [NUM_CPU-1:0]         cpu_irq_o
);

   localparam int NWORD  = NUM_IRQ / 32;
   localparam int NBWORD = NUM_IRQ / 4;

   initial begin
      if (NUM_IRQ % 32 != 0)              $fatal(1, "irq_dist: NUM_IRQ must be a multiple of 32");
      if (NUM_IRQ < 64 || NUM_IRQ > 1024) $fatal(1, "irq_dist: NUM_IRQ must be 64..1024");
      if (NUM_CPU < 1 || NUM_CPU > 8)     $fatal(1, "irq_dist: NUM_CPU must be 1..8");
      if (ADDR_W < 12)                    $fatal(1, "irq_dist: ADDR_W must be at least 12");
      if ((1 << CPU_W) < NUM_CPU)         $fatal(1, "irq_dist: CPU_W too narrow");
   end

   // ---------------- decode ----------------
   logic        hi_zero, wr, rd;
   logic [11:0] a12;
   logic [4:0]  st_slot, st_word;
   logic [1:0]  grp;
   logic [7:0]  bword;
   logic [31:0] wval;

   assign hi_zero = (bus_addr >> 12) == '0;
   assign a12     = bus_addr[11:0];
   assign st_slot = a12[11:7];
   assign st_word = a12[6:2];
   assign grp     = a12[11:10];
   assign bword   = a12[9:2];
   assign wr      = bus_req &  bus_we & hi_zero;
   assign rd      = bus_req & ~bus_we;
   assign wval    = bus_wdata & lane_mask(bus_be);

   logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr, ac_set, ac_clr;

   for (genvar w = 0; w < NWORD; w++) begin : g_word
      logic hit_w;
      assign hit_w = wr && st_word == 5'(w);
      assign en_set[w*32 +: 32] = (hit_w && st_slot == SV_EN_SET) ? wval : '0;
      assign en_clr[w*32 +: 32] = (hit_w && st_slot == SV_EN_CLR) ? wval : '0;
      assign pd_set[w*32 +: 32] = (hit_w && st_slot == SV_PD_SET) ? wval : '0;
      assign pd_clr[w*32 +: 32] = (hit_w && st_slot == SV_PD_CLR) ? wval : '0;
      assign ac_set[w*32 +: 32] = (hit_w && st_slot == SV_AC_SET) ? wval : '0;
      assign ac_clr[w*32 +: 32] = (hit_w && st_slot == SV_AC_CLR) ? wval : '0;
   end

   // ---------------- storage ----------------
   logic                       ctrl_en;
   logic [NUM_IRQ-1:0]         en_q, act_q;
   logic [NUM_IRQ*8-1:0]       prio_q;
   logic [NUM_IRQ*NUM_CPU-1:0] tgt_q;
   logic [NUM_CPU*32-1:0]      bank;
   logic [NUM_IRQ-33:0]        pend_spi;
   logic                       sgi_we;
   logic                       wr_ctrl;

   assign wr_ctrl = wr && a12 == ADR_CTRL && bus_be[0];
   assign sgi_we  = wr && a12 == ADR_SGI;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_en <= 1'b0;
      else if (wr_ctrl) ctrl_en <= bus_wdata[0];
   end

   irq_dist_setclr #(.NUM_IRQ(NUM_IRQ)) u_enable (
      .clk(clk), .rst_n(rst_n), .set_vec(en_set), .clr_vec(en_clr), .state_o(en_q));

   irq_dist_setclr #(.NUM_IRQ(NUM_IRQ)) u_active (
      .clk(clk), .rst_n(rst_n), .set_vec(ac_set), .clr_vec(ac_clr), .state_o(act_q));

   irq_dist_bytes #(.NUM_IRQ(NUM_IRQ), .BYTE_W(8), .FIXED_LOW(0)) u_prio (
      .clk(clk), .rst_n(rst_n), .we(wr && grp == GRP_PRIO), .word(bword),
      .wdata(bus_wdata), .be(bus_be), .bytes_o(prio_q));

   irq_dist_bytes #(.NUM_IRQ(NUM_IRQ), .BYTE_W(NUM_CPU), .FIXED_LOW(32)) u_target (
      .clk(clk), .rst_n(rst_n), .we(wr && grp == GRP_TGT), .word(bword),
      .wdata(bus_wdata), .be(bus_be), .bytes_o(tgt_q));

   irq_dist_pend #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .spi_in(spi_in), .ppi_in(ppi_in),
      .sw_set(pd_set), .sw_clr(pd_clr), .acc_cpu(bus_cpu),
      .sgi_we(sgi_we), .sgi_id(wval[3:0]), .sgi_list(wval[16 +: NUM_CPU]),
      .bank_o(bank), .pend_spi_o(pend_spi));

   // ---------------- read path ----------------
   logic [NUM_CPU-1:0] acc_onehot;
   logic [NUM_IRQ-1:0] pend_view;
   logic [31:0]        rd_val;

   assign acc_onehot = NUM_CPU'(1) << bus_cpu;

   always_comb begin
      pend_view = {pend_spi, 32'b0};
      for (int c = 0; c < NUM_CPU; c++)
         if (bus_cpu == CPU_W'(c)) pend_view[31:0] = bank[c*32 +: 32];
   end

   always_comb begin
      rd_val = '0;
      if (hi_zero) begin
         if (a12 == ADR_CTRL) begin
            rd_val[0] = ctrl_en;
         end else if (a12 == ADR_TYPE) begin
            rd_val[4:0] = 5'(NWORD - 1);
         end else if (grp == GRP_PRIO) begin
            for (int w = 0; w < NBWORD; w++)
               if (bword == 8'(w)) rd_val = prio_q[w*32 +: 32];
         end else if (grp == GRP_TGT) begin
            for (int w = 0; w < NBWORD; w++)
               if (bword == 8'(w))
                  for (int k = 0; k < 4; k++)
                     rd_val[k*8 +: 8] = (w*4 + k < 32) ? 8'(acc_onehot)
                                                      : 8'(tgt_q[(w*4+k)*NUM_CPU +: NUM_CPU]);
         end else begin
            for (int w = 0; w < NWORD; w++)
               if (st_word == 5'(w)) begin
                  case (st_slot)
                     SV_EN_SET, SV_EN_CLR: rd_val = en_q[w*32 +: 32];
                     SV_PD_SET, SV_PD_CLR: rd_val = pend_view[w*32 +: 32];
                     SV_AC_SET, SV_AC_CLR: rd_val = act_q[w*32 +: 32];
                     default:              rd_val = '0;
                  endcase
               end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd ? rd_val : '0;
   end

   // ---------------- forwarding ----------------
   for (genvar c = 0; c < NUM_CPU; c++) begin : g_fwd
      for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
         if (n < 32) begin : g_banked
            assign cpu_hit_o[c*NUM_IRQ+n] = ctrl_en & en_q[n] & bank[c*32+n];
         end else begin : g_shared
            assign cpu_hit_o[c*NUM_IRQ+n] = ctrl_en & en_q[n] & pend_spi[n-32] &
                                            tgt_q[n*NUM_CPU+c];
         end
      end
      assign cpu_irq_o[c] = |cpu_hit_o[c*NUM_IRQ +: NUM_IRQ];
   end

   AST_FWD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !bus_wdata[0]) |=> (cpu_hit_o == '0)); // R10
   AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> (bus_rdata == '0)); // R11
   AST_TYPE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && hi_zero && a12 == ADR_TYPE) |=> (bus_rdata == 32'(NWORD - 1))); // R5
   AST_TGT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && hi_zero && a12 == ADR_TGT0) |=> (bus_rdata == {4{8'($past(acc_onehot))}})); // R4

endmodule

// File: tb/irq_dist_bench.sv
module irq_dist_bench;

   localparam int NI = 64;
   localparam int NC = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_req = 1'b0, bus_we = 1'b0;
   logic [11:0]    bus_addr = '0;
   logic [31:0]    bus_wdata = '0;
   logic [3:0]     bus_be = '0;
   logic [1:0]     bus_cpu = '0;
   logic [31:0]    bus_rdata;
   logic [NI-33:0] spi_in = '0;
   logic [NC*16-1:0] ppi_in = '0;
   logic [NC*NI-1:0] cpu_hit_o;
   logic [NC-1:0]  cpu_irq_o;

   always #4 clk = ~clk;

   irq_dist #(.NUM_IRQ(NI), .NUM_CPU(NC), .ADDR_W(12)) u_irq_dist (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
      .bus_cpu(bus_cpu), .bus_rdata(bus_rdata), .spi_in(spi_in),
      .ppi_in(ppi_in), .cpu_hit_o(cpu_hit_o), .cpu_irq_o(cpu_irq_o));

   int total = 0, bad = 0;

   // ---------------- model ----------------
   logic          m_ctrl;
   logic [NI-1:0] m_en, m_act;
   logic [NI-33:0] m_lat_s, m_spi;
   logic [31:0]   m_lat_b [NC];
   logic [15:0]   m_ppi [NC];
   logic [7:0]    m_prio [NI];
   logic [3:0]    m_tgt [NI];

   task automatic model_reset();
      m_ctrl = 0; m_en = '0; m_act = '0; m_lat_s = '0; m_spi = '0;
      for (int c = 0; c < NC; c++) begin m_lat_b[c] = '0; m_ppi[c] = '0; end
      for (int n = 0; n < NI; n++) begin m_prio[n] = '0; m_tgt[n] = '0; end
   endtask

   function automatic logic pv(int c, int n);
      if (n < 16)      return m_lat_b[c][n];
      else if (n < 32) return m_lat_b[c][n] | m_ppi[c][n-16];
      else             return m_lat_s[n-32] | m_spi[n-32];
   endfunction

   function automatic logic [31:0] exp_read(logic [11:0] a, int cpu);
      logic [31:0] r = '0;
      int w;
      if (a == 12'h000) r[0] = m_ctrl;
      else if (a == 12'h004) r = 32'd1;
      else if (a[11:10] == 2'd1) begin
         w = int'(a[9:2]);
         if (w < NI/4) for (int k = 0; k < 4; k++) r[k*8 +: 8] = m_prio[w*4+k];
      end else if (a[11:10] == 2'd2) begin
         w = int'(a[9:2]);
         if (w < NI/4)
            for (int k = 0; k < 4; k++)
               r[k*8 +: 8] = (w*4+k < 32) ? (8'd1 << cpu) : {4'd0, m_tgt[w*4+k]};
      end else if (a[11:7] >= 5'd2 && a[11:7] <= 5'd7 && a[6:2] < 5'd2) begin
         w = int'(a[6:2]);
         for (int i = 0; i < 32; i++) begin
            case (a[11:7])
               5'd2, 5'd3: r[i] = m_en[w*32+i];
               5'd4, 5'd5: r[i] = pv(cpu, w*32+i);
               default:    r[i] = m_act[w*32+i];
            endcase
         end
      end
      return r;
   endfunction

   function automatic logic [NC*NI-1:0] exp_hit();
      logic [NC*NI-1:0] h = '0;
      for (int c = 0; c < NC; c++)
         for (int n = 0; n < NI; n++)
            h[c*NI+n] = m_ctrl & m_en[n] & pv(c, n) & ((n < 32) ? 1'b1 : m_tgt[n][c]);
      return h;
   endfunction

   task automatic model_write(logic [11:0] a, logic [31:0] d, logic [3:0] be, int cpu);
      logic [31:0] v = d & {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
      int w, n;
      if (a == 12'h000 && be[0]) m_ctrl = d[0];
      else if (a == 12'hF00) begin
         for (int c = 0; c < NC; c++) if (v[16+c]) m_lat_b[c][v[3:0]] = 1'b1;
      end else if (a[11:10] == 2'd1) begin
         w = int'(a[9:2]);
         if (w < NI/4) for (int k = 0; k < 4; k++) if (be[k]) m_prio[w*4+k] = d[k*8 +: 8];
      end else if (a[11:10] == 2'd2) begin
         w = int'(a[9:2]);
         if (w < NI/4)
            for (int k = 0; k < 4; k++) if (be[k] && w*4+k >= 32) m_tgt[w*4+k] = d[k*8 +: 4];
      end else if (a[11:7] >= 5'd2 && a[11:7] <= 5'd7 && a[6:2] < 5'd2) begin
         w = int'(a[6:2]);
         for (int i = 0; i < 32; i++) if (v[i]) begin
            n = w*32 + i;
            case (a[11:7])
               5'd2: m_en[n] = 1'b1;
               5'd3: m_en[n] = 1'b0;
               5'd4: if (n < 32) m_lat_b[cpu][n] = 1'b1; else m_lat_s[n-32] = 1'b1;
               5'd5: if (n < 32) m_lat_b[cpu][n] = 1'b0; else m_lat_s[n-32] = 1'b0;
               5'd6: m_act[n] = 1'b1;
               default: m_act[n] = 1'b0;
            endcase
         end
      end
   endtask

   // ---------------- bus tasks ----------------
   task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] be, int cpu);
      @(negedge clk);
      bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be; bus_cpu = 2'(cpu);
      @(posedge clk);
      model_write(a, d, be, cpu);
      @(negedge clk);
      bus_req = 0; bus_we = 0;
   endtask

   task automatic rd(logic [11:0] a, int cpu, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1; bus_we = 0; bus_addr = a; bus_cpu = 2'(cpu);
      @(posedge clk);
      @(negedge clk);
      bus_req = 0;
      d = bus_rdata;
   endtask

   task automatic set_lines(logic [NI-33:0] s, logic [NC*16-1:0] p);
      @(negedge clk);
      spi_in = s; ppi_in = p;
      @(posedge clk);
      @(negedge clk);
      m_spi = s;
      for (int c = 0; c < NC; c++) m_ppi[c] = p[c*16 +: 16];
   endtask

   task automatic chk(string req, logic [255:0] got, logic [255:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic chk_rd(string req, logic [11:0] a, int cpu);
      logic [31:0] d, e;
      e = exp_read(a, cpu);
      rd(a, cpu, d);
      chk(req, 256'(d), 256'(e));
   endtask

   task automatic chk_hit(string req);
      chk(req, 256'(cpu_hit_o), 256'(exp_hit()));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // ---------------- stimulus ----------------
   logic [11:0] addr_pool [12] = '{12'h000, 12'h004, 12'h100, 12'h184, 12'h200, 12'h284,
                                   12'h300, 12'h384, 12'h408, 12'h838, 12'h804, 12'hF00};

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R12: reset state
      chk("R12 hit", 256'(cpu_hit_o), 256'd0);
      rd(12'h000, 0, d); chk("R12 ctrl", 256'(d), 256'd0);
      rd(12'h104, 0, d); chk("R12 enable", 256'(d), 256'd0);
      rd(12'h43C, 0, d); chk("R12 prio", 256'(d), 256'd0);
      rd(12'h820, 0, d); chk("R12 target", 256'(d), 256'd0);

      // R5: type word, read-only
      rd(12'h004, 1, d); chk("R5 type", 256'(d), 256'd1);
      wr(12'h004, 32'hFFFF_FFFF, 4'hF, 0);
      rd(12'h004, 1, d); chk("R5 type after write", 256'(d), 256'd1);

      // R1/R2: enable set/clear, line 37 -> word 1 bit 5
      wr(12'h104, 32'h0000_0020, 4'hF, 0);
      rd(12'h104, 0, d); chk("R2 line37 bit", 256'(d), 256'h20);
      rd(12'h184, 0, d); chk("R1 clear view reads state", 256'(d), 256'h20);
      wr(12'h104, 32'h0000_0000, 4'hF, 0);
      rd(12'h104, 0, d); chk("R1 zero write keeps", 256'(d), 256'h20);
      wr(12'h184, 32'h0000_0020, 4'hF, 0);
      rd(12'h104, 0, d); chk("R1 clear", 256'(d), 256'h0);
      rd(12'h108, 0, d); chk("R2 beyond lines", 256'(d), 256'h0);

      // R3: priority byte lanes
      wr(12'h404, 32'hA1B2_C3D4, 4'hF, 0);
      wr(12'h404, 32'h5566_7788, 4'b0100, 0);
      rd(12'h404, 0, d); chk("R3 byte strobe", 256'(d), 256'hA166_C3D4);

      // R4: targets
      wr(12'h820, 32'hFFFF_FFFF, 4'b0010, 0);
      rd(12'h820, 0, d); chk("R4 upper bits dropped", 256'(d), 256'h0000_0F00);
      wr(12'h800, 32'hFFFF_FFFF, 4'hF, 0);
      rd(12'h800, 2, d); chk("R4 banked target", 256'(d), 256'h0404_0404);

      // R6: software fan-out to cpus 1 and 3, line 5
      wr(12'hF00, 32'h000A_0005, 4'hF, 0);
      rd(12'h200, 1, d); chk("R6 cpu1", 256'(d), 256'h20);
      rd(12'h200, 3, d); chk("R6 cpu3", 256'(d), 256'h20);
      rd(12'h200, 0, d); chk("R6 cpu0 untouched", 256'(d), 256'h0);

      // R7: banked clear only touches the accessing cpu
      wr(12'h280, 32'h0000_0020, 4'hF, 1);
      rd(12'h200, 1, d); chk("R7 cpu1 cleared", 256'(d), 256'h0);
      rd(12'h200, 3, d); chk("R7 cpu3 kept", 256'(d), 256'h20);

      // R8: level line 40
      set_lines(32'h0000_0100, '0);
      rd(12'h204, 0, d); chk("R8 level pending", 256'(d), 256'h100);
      wr(12'h284, 32'h0000_0100, 4'hF, 0);
      rd(12'h204, 0, d); chk("R8 clear while high", 256'(d), 256'h100);
      set_lines('0, '0);
      rd(12'h204, 0, d); chk("R8 dropped", 256'(d), 256'h0);

      // R9/R10: forwarding of line 40 to cpu 2
      set_lines(32'h0000_0100, '0);
      wr(12'h104, 32'h0000_0100, 4'hF, 0);
      wr(12'h828, 32'h0000_0004, 4'b0001, 0);
      chk("R10 off gates", 256'(cpu_hit_o), 256'd0);
      wr(12'h000, 32'h1, 4'hF, 0);
      chk("R9 hit cpu2 line40", 256'(cpu_hit_o), 256'(exp_hit()));
      chk("R9 irq summary", 256'(cpu_irq_o), 256'h4);
      wr(12'h000, 32'h0, 4'hF, 0);
      chk("R10 off again", 256'(cpu_hit_o), 256'd0);

      // R11: unmapped and write-only
      rd(12'hF00, 0, d); chk("R11 fan-out reads zero", 256'(d), 256'h0);
      rd(12'h010, 0, d); chk("R11 unmapped", 256'(d), 256'h0);
      @(negedge clk); chk("R11 idle zero", 256'(bus_rdata), 256'h0);

      // random phase, all requirements
      for (int it = 0; it < 400; it++) begin
         int op = int'($urandom_range(0, 9));
         int cpu = int'($urandom_range(0, NC-1));
         logic [11:0] a = addr_pool[$urandom_range(0, 11)];
         if (op < 2) set_lines(32'($urandom) & 32'h0000_F0F0, 64'({$urandom, $urandom}) & 64'h000F_000F_000F_000F);
         else wr(a, $urandom, 4'($urandom), cpu);
         chk("R9 random hit", 256'(cpu_hit_o), 256'(exp_hit()));
         chk_rd("R1 R3 R4 R7 random read", addr_pool[$urandom_range(0, 11)], int'($urandom_range(0, NC-1)));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule